// File: doc/BRIEF.md
# Iterative Triple-DES Cipher Engine

This engine encrypts or decrypts one 64-bit block with triple DES. It computes one DES round per clock, so a block takes 48 cycles: three passes of 16 rounds. The engine holds no key storage. The user keeps the three sub-keys and drives one of them on a single 64-bit key port. A 2-bit select output names the sub-key the engine wants next. That sub-key is sampled on the edge that opens each pass.

Encryption runs encrypt with sub-key 1, then decrypt with sub-key 2, then encrypt with sub-key 3. Decryption runs the reverse chain: decrypt with sub-key 3, encrypt with sub-key 2, decrypt with sub-key 1. The result is shown together with a one-cycle valid pulse. Holding the enable high keeps blocks streaming with no gap between them. The user presents the next data word and its first sub-key on the edge right after the valid cycle.

Top module: `tdes_core`

## Requirements
- R1: With `en_i` held high from the edge that starts cycle 1, `valid_o` is high in cycle 48 and `data_o` then carries the triple-DES result. Bit 63 of each 64-bit port is the first bit in DES numbering.
- R2: `valid_o` is high for exactly one cycle per completed block.
- R3: When `encrypt_i` is 1, the result is E(k3, D(k2, E(k1, x))). `key_sel_o` reads 00, then 01, then 10, naming k1, k2 and k3 in turn. Single DES vectors are met when all three sub-keys are equal.
- R4: When `encrypt_i` is 0, the result is D(k1, E(k2, D(k3, y))). `key_sel_o` reads 10, then 01, then 00.
- R5: `key_sel_o` moves to the second sub-key at the edge that starts cycle 16 and to the third at the edge that starts cycle 32. The key port is sampled only at the edges that start cycles 1, 17 and 33, and its value at any other edge has no effect.
- R6: A new block can start on the edge right after the valid cycle (cycle 49) with no idle cycles, and it gives its own correct result 48 cycles later.
- R7: Dropping `en_i` aborts the block in progress. No valid pulse is produced, and the next assertion of `en_i` starts a fresh block from cycle 1.
- R8: The DES parity bits are ignored. These are bits 0, 8, …, 56 of `key_i`, the LSB of each byte.
- R9: `encrypt_i` and `data_i` are sampled only at the edge that starts a block, and later changes to them have no effect. While idle, `key_sel_o` names the first sub-key for the current `encrypt_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; held high for the whole block |
| encrypt_i | input | 1 | 1 selects encryption, 0 selects decryption |
| data_i | input | 64 | Plaintext or ciphertext, sampled at block start |
| key_i | input | 64 | The sub-key named by key_sel_o |
| key_sel_o | output | 2 | Sub-key request: 00 = k1, 01 = k2, 10 = k3 |
| data_o | output | 64 | Result, valid while valid_o is high |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The bench drives junk on the key and data ports on every edge except those where the engine samples them. A design that read the key one edge early or late, or that missed the one-cycle slack, gives a wrong ciphertext. Sub-key choices where two keys are equal turn the three-pass chain into plain DES with a known answer, so a swapped key order or a swapped pass direction shows up as a mismatch. Other tests flip the mode mid-block, run blocks back to back, abort a block and flip the parity bits. These catch a design that re-samples its mode, needs a gap between blocks, leaks a valid after an abort, or uses the parity bits.

// File: rtl/tdes_pkg.sv
package tdes_pkg;
  localparam int unsigned BLK_W   = 64;
  localparam int unsigned HALF_W  = BLK_W / 2;
  localparam int unsigned CD_W    = 56;
  localparam int unsigned SUBK_W  = 48;
  localparam int unsigned ROUNDS  = 16;
  localparam int unsigned PASSES  = 3;
  localparam int unsigned TOTAL   = ROUNDS * PASSES;
  localparam int unsigned CNT_W   = $clog2(TOTAL);

  localparam int unsigned IP_T[64] = '{58,50,42,34,26,18,10,2,60,52,44,36,28,20,12,4,
    62,54,46,38,30,22,14,6,64,56,48,40,32,24,16,8,57,49,41,33,25,17,9,1,
    59,51,43,35,27,19,11,3,61,53,45,37,29,21,13,5,63,55,47,39,31,23,15,7};
  localparam int unsigned FP_T[64] = '{40,8,48,16,56,24,64,32,39,7,47,15,55,23,63,31,
    38,6,46,14,54,22,62,30,37,5,45,13,53,21,61,29,36,4,44,12,52,20,60,28,
    35,3,43,11,51,19,59,27,34,2,42,10,50,18,58,26,33,1,41,9,49,17,57,25};
  localparam int unsigned E_T[48] = '{32,1,2,3,4,5,4,5,6,7,8,9,8,9,10,11,12,13,12,13,
    14,15,16,17,16,17,18,19,20,21,20,21,22,23,24,25,24,25,26,27,28,29,28,29,30,31,32,1};
  localparam int unsigned P_T[32] = '{16,7,20,21,29,12,28,17,1,15,23,26,5,18,31,10,
    2,8,24,14,32,27,3,9,19,13,30,6,22,11,4,25};
  localparam int unsigned PC1_T[56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,
    10,2,59,51,43,35,27,19,11,3,60,52,44,36,63,55,47,39,31,23,15,7,
    62,54,46,38,30,22,14,6,61,53,45,37,29,21,13,5,28,20,12,4};
  localparam int unsigned PC2_T[48] = '{14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,
    26,8,16,7,27,20,13,2,41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,
    34,53,46,42,50,36,29,32};

  // each box: 64 nibbles, row-major (row = outer bits, col = inner four)
  localparam logic [255:0] SBOX_T[8] = '{
    256'he4d12fb83a6c5907_0f74e2d1a6cb9538_41e8d62bfc973a50_fc8249175b3ea06d,
    256'hf18e6b34972dc05a_3d47f28ec01a69b5_0e7ba4d158c6932f_d8a13f42b67c05e9,
    256'ha09e63f51dc7b428_d70934a6285ecbf1_d6498f30b12c5ae7_1ad069874fe3b52c,
    256'h7de3069a1285bc4f_d8b56f03472c1ae9_a690cb7df13e5284_3f06a1d8945bc72e,
    256'h2c417ab6853fd0e9_eb2c47d150fa3986_421bad78f9c5630e_b8c71e2d6f09a453,
    256'hc1af92680d34e75b_af427c9561de0b38_9ef528c3704a1db6_432c95fabe17608d,
    256'h4b2ef08d3c975a61_d0b7491ae35c2f86_14bdc37eaf680592_6bd814a7950fe23c,
    256'hd2846fb1a93e50c7_1fd8a374c56b0e92_7b419ce206adf358_21e74a8dfc90356b};

  function automatic logic [63:0] perm_ip(input logic [63:0] x);
    for (int i = 0; i < 64; i++) perm_ip[63-i] = x[64-IP_T[i]];
  endfunction
  function automatic logic [63:0] perm_fp(input logic [63:0] x);
    for (int i = 0; i < 64; i++) perm_fp[63-i] = x[64-FP_T[i]];
  endfunction
  function automatic logic [47:0] perm_e(input logic [31:0] x);
    for (int i = 0; i < 48; i++) perm_e[47-i] = x[32-E_T[i]];
  endfunction
  function automatic logic [31:0] perm_p(input logic [31:0] x);
    for (int i = 0; i < 32; i++) perm_p[31-i] = x[32-P_T[i]];
  endfunction
  function automatic logic [55:0] perm_pc1(input logic [63:0] x);
    for (int i = 0; i < 56; i++) perm_pc1[55-i] = x[64-PC1_T[i]];
  endfunction
  function automatic logic [47:0] perm_pc2(input logic [55:0] x);
    for (int i = 0; i < 48; i++) perm_pc2[47-i] = x[56-PC2_T[i]];
  endfunction
endpackage

// File: rtl/tdes_ctrl.sv
module tdes_ctrl
  import tdes_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             encrypt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             blk_start_o,
  output logic             pass_enc_o,
  output logic             last_o,
  output logic [1:0]       key_sel_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mode_q, mode_eff, valid_q;
  logic [1:0]       pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      mode_q  <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      valid_q <= en_i && (cnt_q == LAST);
      if (!en_i || cnt_q == LAST) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
      if (en_i && cnt_q == '0) mode_q <= encrypt_i;
    end
  end

  assign blk_start_o = (cnt_q == '0);
  assign last_o      = (cnt_q == LAST);
  assign mode_eff    = blk_start_o ? encrypt_i : mode_q;
  assign pass        = cnt_q[CNT_W-1 -: 2];
  assign pass_enc_o  = mode_eff ^ (pass == 2'd1);
  assign key_sel_o   = mode_eff ? pass : 2'd2 - pass;
  assign cnt_o       = cnt_q;
  assign valid_o     = valid_q;

  // R2
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R7
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0 && !valid_o));
  // R5
  ksel_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == CNT_W'(ROUNDS - 1)) |=> (key_sel_o != $past(key_sel_o)));
  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(cnt_q) == LAST && $past(en_i)));
  // R3
  ksel_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_sel_o != 2'b11);
endmodule

// File: rtl/tdes_keystep.sv
module tdes_keystep
  import tdes_pkg::*;
(
  input  logic [BLK_W-1:0]  key_i,
  input  logic [CD_W-1:0]   cd_i,
  input  logic              pass_start_i,
  input  logic              pass_enc_i,
  input  logic [3:0]        rnd_i,
  output logic [SUBK_W-1:0] subkey_o,
  output logic [CD_W-1:0]   cd_o
);
  localparam int unsigned HW = CD_W / 2;

  logic [CD_W-1:0] src, used;
  logic [HW-1:0]   c, d;
  logic            one_enc, one_dec;

  assign src     = pass_start_i ? perm_pc1(key_i) : cd_i;
  assign c       = src[CD_W-1:HW];
  assign d       = src[HW-1:0];
  // single-position shift rounds; decrypt mirrors the schedule
  assign one_enc = (rnd_i == 4'd0) || (rnd_i == 4'd1) || (rnd_i == 4'd8) || (rnd_i == 4'd15);
  assign one_dec = (rnd_i == 4'd0) || (rnd_i == 4'd7) || (rnd_i == 4'd14) || (rnd_i == 4'd15);

  always_comb begin
    if (pass_enc_i) begin
      used = one_enc ? {c[HW-2:0], c[HW-1], d[HW-2:0], d[HW-1]}
                     : {c[HW-3:0], c[HW-1:HW-2], d[HW-3:0], d[HW-1:HW-2]};
      cd_o = used;
    end else begin
      used = src;
      cd_o = one_dec ? {c[0], c[HW-1:1], d[0], d[HW-1:1]}
                     : {c[1:0], c[HW-1:2], d[1:0], d[HW-1:2]};
    end
  end

  assign subkey_o = perm_pc2(used);
endmodule

// File: rtl/tdes_round.sv
module tdes_round
  import tdes_pkg::*;
(
  input  logic [BLK_W-1:0]  lr_i,
  input  logic [SUBK_W-1:0] subkey_i,
  output logic [BLK_W-1:0]  lr_o
);
  logic [HALF_W-1:0] l, r, sout;
  logic [SUBK_W-1:0] x;

  assign l = lr_i[BLK_W-1:HALF_W];
  assign r = lr_i[HALF_W-1:0];
  assign x = perm_e(r) ^ subkey_i;

  always_comb begin
    sout = '0;
    for (int s = 0; s < 8; s++) begin
      logic [5:0] six;
      logic [5:0] idx;
      six = x[SUBK_W-1-6*s -: 6];
      idx = {six[5], six[0], six[4:1]};
      sout[HALF_W-1-4*s -: 4] = SBOX_T[s][255-4*idx -: 4];
    end
  end

  assign lr_o = {r, l ^ perm_p(sout)};
endmodule

// File: rtl/tdes_core.sv
module tdes_core
  import tdes_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        encrypt_i,
  input  logic [63:0] data_i,
  input  logic [63:0] key_i,
  output logic [1:0]  key_sel_o,
  output logic [63:0] data_o,
  output logic        valid_o
);
  logic [CNT_W-1:0]  cnt;
  logic              blk_start, pass_enc, last, pass_start;
  logic [BLK_W-1:0]  lr_q, lr_src, lr_nxt, res_q;
  logic [CD_W-1:0]   cd_q, cd_nxt;
  logic [SUBK_W-1:0] subkey;

  tdes_ctrl u_ctrl (
    .clk_i, .rst_ni, .en_i, .encrypt_i,
    .cnt_o(cnt), .blk_start_o(blk_start), .pass_enc_o(pass_enc),
    .last_o(last), .key_sel_o, .valid_o
  );

  assign pass_start = (cnt[3:0] == 4'd0);

  // FP then IP between passes cancel; only the half swap remains
  always_comb begin
    if (blk_start)       lr_src = perm_ip(data_i);
    else if (pass_start) lr_src = {lr_q[HALF_W-1:0], lr_q[BLK_W-1:HALF_W]};
    else                 lr_src = lr_q;
  end

  tdes_keystep u_key (
    .key_i, .cd_i(cd_q), .pass_start_i(pass_start), .pass_enc_i(pass_enc),
    .rnd_i(cnt[3:0]), .subkey_o(subkey), .cd_o(cd_nxt)
  );

  tdes_round u_round (.lr_i(lr_src), .subkey_i(subkey), .lr_o(lr_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q  <= '0;
      cd_q  <= '0;
      res_q <= '0;
    end else if (en_i) begin
      lr_q <= lr_nxt;
      cd_q <= cd_nxt;
      if (last) res_q <= perm_fp({lr_nxt[HALF_W-1:0], lr_nxt[BLK_W-1:HALF_W]});
    end
  end

  assign data_o = res_q;

  // R1
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_i) || !$past(last)) |-> $stable(data_o));
endmodule

// File: tb/tb_tdes_core.sv
module tb_tdes_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        encrypt_i = 1'b1;
  logic [63:0] data_i = '0;
  logic [63:0] key_i = '0;
  logic [1:0]  key_sel_o;
  logic [63:0] data_o;
  logic        valid_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  localparam logic [63:0] KA = 64'h133457799BBCDFF1;
  localparam logic [63:0] KB = 64'h0123456789ABCDEF;
  localparam logic [63:0] KC = 64'hFEDCBA9876543210;
  localparam logic [63:0] PA = 64'h0123456789ABCDEF;
  localparam logic [63:0] CA = 64'h85E813540F0AB405;
  localparam logic [63:0] PB = 64'h4E6F772069732074;
  localparam logic [63:0] CB = 64'h3FA40E8A984D4815;

  tdes_core dut (.clk_i(clk), .rst_ni, .en_i, .encrypt_i, .data_i, .key_i,
                 .key_sel_o, .data_o, .valid_o);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one block; leaves the bench at the negedge after the valid cycle, en_i still high
  task automatic run_blk(input logic m, input logic [63:0] d, input logic [63:0] k1,
                         input logic [63:0] k2, input logic [63:0] k3, input bit do_chk,
                         input logic [63:0] exp, input bit flip_mode, input string req,
                         output logic [63:0] got);
    logic [63:0] ks [3];
    logic [1:0]  first, third;
    ks[0] = k1; ks[1] = k2; ks[2] = k3;
    first = m ? 2'd0 : 2'd2;
    third = m ? 2'd2 : 2'd0;
    encrypt_i = m; data_i = d; en_i = 1'b1;
    #1;
    check(key_sel_o == first, "R9 idle key_sel", 64'(key_sel_o), 64'(first));
    key_i = ks[first];
    got = '0;
    for (int cyc = 1; cyc <= 48; cyc++) begin
      @(negedge clk);
      key_i  = 64'hBAD0_0000_0000_0000 ^ 64'(cyc);
      data_i = 64'h5A5A_0000_0000_0000 ^ 64'(cyc);
      if (flip_mode) encrypt_i = ~m;
      if (cyc == 15) check(key_sel_o == first, "R5 key_sel cycle 15", 64'(key_sel_o), 64'(first));
      if (cyc == 16) begin
        check(key_sel_o == 2'd1, "R5 key_sel cycle 16", 64'(key_sel_o), 64'd1);
        key_i = ks[1];
      end
      if (cyc == 32) begin
        check(key_sel_o == third, "R5 key_sel cycle 32", 64'(key_sel_o), 64'(third));
        key_i = ks[third];
      end
      if (cyc == 47) check(valid_o == 1'b0, "R1 no early valid", 64'(valid_o), 64'd0);
      if (cyc == 48) begin
        check(valid_o == 1'b1, "R1 valid in cycle 48", 64'(valid_o), 64'd1);
        got = data_o;
        if (do_chk) check(got == exp, req, got, exp);
      end
    end
    encrypt_i = m;
  endtask

  task automatic t_reset();
    check(valid_o == 1'b0, "R2 reset valid", 64'(valid_o), 64'd0);
    check(data_o == '0, "R1 reset data", data_o, 64'd0);
    check(key_sel_o == 2'd0, "R9 reset key_sel", 64'(key_sel_o), 64'd0);
  endtask

  task automatic t_single_des();
    logic [63:0] g;
    run_blk(1'b1, PA, KA, KA, KA, 1'b1, CA, 1'b0, "R3 encrypt equal keys", g);
    run_blk(1'b0, CA, KA, KA, KA, 1'b1, PA, 1'b0, "R4 decrypt equal keys", g);
    en_i = 1'b0;
    @(negedge clk);
    check(valid_o == 1'b0, "R2 valid one cycle", 64'(valid_o), 64'd0);
  endtask

  task automatic t_key_order();
    logic [63:0] g;
    // E(KA, D(KB, E(KB, x))) == E(KA, x)
    run_blk(1'b1, PA, KB, KB, KA, 1'b1, CA, 1'b0, "R3 k3 used last", g);
    en_i = 1'b0; @(negedge clk);
    // D(KA, E(KB, D(KB, y))) == D(KA, y)
    run_blk(1'b0, CA, KA, KB, KB, 1'b1, PA, 1'b0, "R4 k1 used last", g);
    en_i = 1'b0; @(negedge clk);
  endtask

  task automatic t_back_to_back();
    logic [63:0] g;
    run_blk(1'b1, PA, KA, KA, KA, 1'b1, CA, 1'b0, "R6 first of pair", g);
    run_blk(1'b1, PB, KB, KB, KB, 1'b1, CB, 1'b0, "R6 second of pair", g);
    run_blk(1'b0, CB, KB, KB, KB, 1'b1, PB, 1'b0, "R6 third decrypt", g);
    en_i = 1'b0; @(negedge clk);
  endtask

  task automatic t_parity();
    logic [63:0] g;
    logic [63:0] kp;
    kp = KA ^ 64'h0101010101010101;
    run_blk(1'b1, PA, kp, kp, kp, 1'b1, CA, 1'b0, "R8 parity bits ignored", g);
    en_i = 1'b0; @(negedge clk);
  endtask

  task automatic t_abort();
    logic [63:0] g;
    bit seen;
    encrypt_i = 1'b1; data_i = PB; key_i = KA; en_i = 1'b1;
    for (int i = 0; i < 20; i++) @(negedge clk);
    en_i = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (valid_o) seen = 1'b1;
    end
    check(!seen, "R7 no valid after abort", 64'(seen), 64'd0);
    run_blk(1'b1, PA, KA, KA, KA, 1'b1, CA, 1'b0, "R7 fresh block after abort", g);
    en_i = 1'b0; @(negedge clk);
  endtask

  task automatic t_mode_hold();
    logic [63:0] g;
    run_blk(1'b1, PB, KB, KB, KB, 1'b1, CB, 1'b1, "R9 mode held after start", g);
    en_i = 1'b0; @(negedge clk);
  endtask

  task automatic t_round_trip();
    logic [63:0] c, p;
    run_blk(1'b1, PB, KA, KB, KC, 1'b0, '0, 1'b0, "R3 distinct keys", c);
    check(c != PB, "R3 ciphertext differs", c, PB);
    run_blk(1'b0, c, KA, KB, KC, 1'b1, PB, 1'b0, "R4 round trip", p);
    en_i = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_single_des();
    t_key_order();
    t_back_to_back();
    t_parity();
    t_abort();
    t_mode_hold();
    t_round_trip();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule